// File: doc/BRIEF.md
# USB Host Controller Command and Halt Sequencer

This block is the command-register control core of a USB host controller. Software writes a five-bit command word that holds the run/stop request, a self-clearing controller reset, the periodic schedule enable and the frame list size. The block keeps the halted status consistent with the run request. Once run is cleared, it carries out a bounded drain of pending transactions before it reports halted. It also runs a fixed-length internal reset sequence that software cannot cut short, and it derives the frame list index from a microframe counter.

Schedule walking, bus transactions and port logic sit outside the block. They are seen only through a `txn_pending` level, a `mem_rd_err` pulse and a `uframe_tick` pulse that arrives once per 125 µs microframe.

The controller state machine has four states:
- HALTED: idle, with halted reported.
- RUNNING: executing the schedule.
- DRAIN: run has been cleared and pending work is finishing.
- RESET: the internal reset sequence is in progress.

Its transitions are:
- HALTED→RUNNING on a run write.
- RUNNING→DRAIN on a stop write or a memory read error.
- DRAIN→HALTED when pending work has drained, or forced at the microframe deadline.
- Any state→RESET on a reset write. This does not apply while already in RESET.
- RESET→HALTED when the reset cycle count expires.

Top module: `hc_cmd_ctrl`

## Requirements
- R1: After `rst_n` deasserts, the outputs are as follows: `halted`=1, `cmd_rdata`=0, `host_err`=0, `halt_timeout`=0, `reset_active`=0, `periodic_en`=0, `frame_list_idx`=0.
- R2: The command word layout is: bit 0 run, bit 1 reset, bits 3:2 list size, bit 4 periodic enable. A write with bit 0 = 1 and bit 1 = 0 while halted makes run read 1 and `halted` read 0 from the next cycle. Run and `halted` are never 1 together.
- R3: A write with bit 0 = 0 while running makes run read 0 on the next cycle. `halted` stays 0 while `txn_pending` is 1, and becomes 1 one cycle after `txn_pending` is seen low.
- R4: If `txn_pending` is still 1 at the 16th `uframe_tick` after stop, `halted` becomes 1 and `halt_timeout` becomes 1 on that tick. `halt_timeout` clears on the next run start or reset.
- R5: A write of run = 1 while the halt drain is in progress is ignored. Run keeps reading 0.
- R6: A `mem_rd_err` pulse while running clears run and sets `host_err`. The drain sequence of R3 then follows. `host_err` stays set until a reset.
- R7: A write with bit 1 = 1 makes the reset bit read 1, with `reset_active`=1 and `halted`=0, for exactly 4 cycles. After that, run reads 0, `halted` reads 1, and every field, flag and the frame counter are back to their R1 values.
- R8: Every write made while a reset is in progress is ignored. This includes writing 0 to the reset bit.
- R9: List size codes are 00 = 1024, 01 = 512 and 10 = 256 entries. The field changes only when `prog_fl_cap` is 1. A write of code 11 leaves it unchanged.
- R10: Bit 4 is stored and read back, and it drives `periodic_en`.
- R11: The microframe counter advances by one per `uframe_tick` while running or draining, and holds otherwise. `frame_list_idx` is the counter shifted right by 3, masked to 10, 9 or 8 bits for size 00, 01 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 5 | Command word write data |
| cmd_rdata | output | 5 | Command word read-back |
| prog_fl_cap | input | 1 | Frame list size is programmable when 1 |
| uframe_tick | input | 1 | One-cycle pulse per microframe |
| txn_pending | input | 1 | Transactions still in flight |
| mem_rd_err | input | 1 | Failed memory read status pulse |
| halted | output | 1 | Controller halted status |
| host_err | output | 1 | Sticky host error flag |
| halt_timeout | output | 1 | Halt was forced at the deadline |
| reset_active | output | 1 | Internal reset sequence in progress |
| periodic_en | output | 1 | Periodic schedule processing enabled |
| frame_list_idx | output | 10 | Current frame list index |

## Verification
The bench targets the following corner cases:
- **Drain deadline.** It checks that `halted` is still 0 after 15 ticks and 1 on the 16th. A design that counted one tick too few or too many would halt early or late.
- **Abort attempts during reset.** It writes during the reset sequence, with the reset bit at 0, and checks that the sequence still lasts exactly four cycles and that the written fields are not kept. A design without this protection would end the reset early or latch the stray fields.
- **Run writes during drain.** It checks that a run write during the drain leaves run at 0. A design that accepted it would restart the controller with halted and run in conflict.
- **List size handling.** It checks the size field with the capability input low and with the reserved code. It also checks the index at a counter value past 256 frames, where a wrong mask gives a different index.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

    localparam int CMD_W = 5;
    localparam int B_RUN = 0;
    localparam int B_RST = 1;
    localparam int B_SZ_LO = 2;
    localparam int B_SZ_HI = 3;
    localparam int B_PER = 4;

    localparam logic [1:0] SZ_1024 = 2'b00;
    localparam logic [1:0] SZ_512  = 2'b01;
    localparam logic [1:0] SZ_256  = 2'b10;
    localparam logic [1:0] SZ_RSVD = 2'b11;

    typedef enum logic [1:0] {
        ST_HALTED  = 2'd0,
        ST_RUNNING = 2'd1,
        ST_DRAIN   = 2'd2,
        ST_RESET   = 2'd3
    } hc_state_e;

endpackage

// File: rtl/hcc_ctrl_fsm.sv
module hcc_ctrl_fsm
    import hcc_pkg::*;
#(
    parameter int HALT_UF = 16,
    parameter int RST_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_set,
    input  logic run_clr,
    input  logic rst_req,
    input  logic mem_rd_err,
    input  logic txn_pending,
    input  logic uframe_tick,
    output logic run_o,
    output logic halted_o,
    output logic rst_busy_o,
    output logic rst_start_o,
    output logic host_err_o,
    output logic timeout_o,
    output logic cnt_en_o
);

    localparam int HCW = $clog2(HALT_UF + 1);
    localparam int RCW = $clog2(RST_CYC + 1);

    hc_state_e state_q, state_d;
    logic [HCW-1:0] hcnt_q;
    logic [RCW-1:0] rcnt_q;
    logic host_err_q, timeout_q;
    logic deadline_hit, rst_done, rst_start;

    assign deadline_hit = uframe_tick && (hcnt_q == HCW'(HALT_UF - 1));
    assign rst_done     = (rcnt_q == RCW'(RST_CYC - 1));
    assign rst_start    = rst_req && (state_q != ST_RESET);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALTED: begin
                if (rst_req)      state_d = ST_RESET;
                else if (run_set) state_d = ST_RUNNING;
            end
            ST_RUNNING: begin
                if (rst_req)                   state_d = ST_RESET;
                else if (mem_rd_err || run_clr) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (rst_req)           state_d = ST_RESET;
                else if (!txn_pending) state_d = ST_HALTED;
                else if (deadline_hit) state_d = ST_HALTED;
            end
            ST_RESET: begin
                if (rst_done) state_d = ST_HALTED;
            end
            default: state_d = ST_HALTED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_HALTED;
            hcnt_q     <= '0;
            rcnt_q     <= '0;
            host_err_q <= 1'b0;
            timeout_q  <= 1'b0;
        end else begin
            state_q <= state_d;

            if (state_q != ST_DRAIN)  hcnt_q <= '0;
            else if (uframe_tick)     hcnt_q <= hcnt_q + 1'b1;

            if (state_q != ST_RESET)  rcnt_q <= '0;
            else                      rcnt_q <= rcnt_q + 1'b1;

            if (rst_start)
                host_err_q <= 1'b0;
            else if (mem_rd_err && (state_q == ST_RUNNING || state_q == ST_DRAIN))
                host_err_q <= 1'b1;

            if (rst_start)
                timeout_q <= 1'b0;
            else if (state_q == ST_HALTED && state_d == ST_RUNNING)
                timeout_q <= 1'b0;
            else if (state_q == ST_DRAIN && !rst_req && txn_pending && deadline_hit)
                timeout_q <= 1'b1;
        end
    end

    always_comb begin
        run_o       = (state_q == ST_RUNNING);
        halted_o    = (state_q == ST_HALTED);
        rst_busy_o  = (state_q == ST_RESET);
        cnt_en_o    = (state_q == ST_RUNNING) || (state_q == ST_DRAIN);
        rst_start_o = rst_start;
        host_err_o  = host_err_q;
        timeout_o   = timeout_q;
    end

    // R2: run and halted never read 1 together
    a_r2_run_halt_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_o && halted_o));

    // R2: a run write from the halted state clears halted on the next cycle
    a_r2_halt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && run_set && !rst_req) |=> (run_o && !halted_o));

    // R4: the drain never counts past the microframe deadline
    a_r4_deadline_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN) |-> (hcnt_q < HCW'(HALT_UF)));

    // R6: a memory read error while running stops the run and flags the error
    a_r6_mem_err: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && mem_rd_err && !rst_req) |=> (!run_o && host_err_o));

    // R8: a reset that has begun lasts beyond its first cycle
    a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_busy_o) |=> rst_busy_o);

    // R7: the end of a reset always lands in the halted state
    a_r7_reset_ends_halted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_busy_o) |-> halted_o);

endmodule

// File: rtl/hcc_cfg_regs.sv
module hcc_cfg_regs
    import hcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_size,
    input  logic       wr_per,
    input  logic       size_cap,
    input  logic       clr,
    output logic [1:0] size_o,
    output logic       per_o
);

    logic [1:0] size_q;
    logic       per_q;
    logic       size_ok;

    assign size_ok = size_cap && (wr_size != SZ_RSVD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q <= SZ_1024;
            per_q  <= 1'b0;
        end else if (clr) begin
            size_q <= SZ_1024;
            per_q  <= 1'b0;
        end else if (wr_en) begin
            per_q <= wr_per;
            if (size_ok) size_q <= wr_size;
        end
    end

    assign size_o = size_q;
    assign per_o  = per_q;

    // R9: the size field never holds the reserved code
    a_r9_no_rsvd: assert property (@(posedge clk) disable iff (!rst_n)
        size_q != SZ_RSVD);

    // R9: without the capability input the size field does not move
    a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!size_cap && !clr) |=> $stable(size_q));

endmodule

// File: rtl/hcc_frame_index.sv
module hcc_frame_index
    import hcc_pkg::*;
#(
    parameter int FCNT_W = 14,
    parameter int FL_W   = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            cnt_en,
    input  logic            clr,
    input  logic [1:0]      size,
    output logic [FL_W-1:0] idx_o
);

    logic [FCNT_W-1:0] fcnt_q;
    logic [FL_W-1:0]   idx_full;
    logic [FL_W-1:0]   mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              fcnt_q <= '0;
        else if (clr)            fcnt_q <= '0;
        else if (tick && cnt_en) fcnt_q <= fcnt_q + 1'b1;
    end

    assign idx_full = fcnt_q[FL_W+2:3];

    always_comb begin
        unique case (size)
            SZ_1024: mask = {FL_W{1'b1}};
            SZ_512:  mask = {1'b0, {(FL_W-1){1'b1}}};
            default: mask = {2'b00, {(FL_W-2){1'b1}}};
        endcase
    end

    assign idx_o = idx_full & mask;

    // R11: without an enabled tick the counter holds
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tick && cnt_en) && !clr) |=> $stable(fcnt_q));

    // R11: an enabled tick advances the counter by one
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_en && !clr) |=> (fcnt_q == $past(fcnt_q) + 1'b1));

endmodule

// File: rtl/hc_cmd_ctrl.sv
module hc_cmd_ctrl
    import hcc_pkg::*;
#(
    parameter int HALT_UF = 16,
    parameter int RST_CYC = 4,
    parameter int FCNT_W  = 14,
    parameter int FL_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we,
    input  logic [CMD_W-1:0] cmd_wdata,
    output logic [CMD_W-1:0] cmd_rdata,
    input  logic             prog_fl_cap,
    input  logic             uframe_tick,
    input  logic             txn_pending,
    input  logic             mem_rd_err,
    output logic             halted,
    output logic             host_err,
    output logic             halt_timeout,
    output logic             reset_active,
    output logic             periodic_en,
    output logic [FL_W-1:0]  frame_list_idx
);

    logic rst_req, run_set, run_clr;
    logic run_s, rst_busy, rst_start, cnt_en;
    logic cfg_wr;
    logic [1:0] size_s;

    assign rst_req = cmd_we && cmd_wdata[B_RST];
    assign run_set = cmd_we && !cmd_wdata[B_RST] && cmd_wdata[B_RUN];
    assign run_clr = cmd_we && !cmd_wdata[B_RST] && !cmd_wdata[B_RUN];
    assign cfg_wr  = cmd_we && !cmd_wdata[B_RST] && !rst_busy;

    hcc_ctrl_fsm #(
        .HALT_UF (HALT_UF),
        .RST_CYC (RST_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_set     (run_set),
        .run_clr     (run_clr),
        .rst_req     (rst_req),
        .mem_rd_err  (mem_rd_err),
        .txn_pending (txn_pending),
        .uframe_tick (uframe_tick),
        .run_o       (run_s),
        .halted_o    (halted),
        .rst_busy_o  (rst_busy),
        .rst_start_o (rst_start),
        .host_err_o  (host_err),
        .timeout_o   (halt_timeout),
        .cnt_en_o    (cnt_en)
    );

    hcc_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wr_size  (cmd_wdata[B_SZ_HI:B_SZ_LO]),
        .wr_per   (cmd_wdata[B_PER]),
        .size_cap (prog_fl_cap),
        .clr      (rst_start),
        .size_o   (size_s),
        .per_o    (periodic_en)
    );

    hcc_frame_index #(
        .FCNT_W (FCNT_W),
        .FL_W   (FL_W)
    ) u_fidx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (uframe_tick),
        .cnt_en (cnt_en),
        .clr    (rst_start),
        .size   (size_s),
        .idx_o  (frame_list_idx)
    );

    assign reset_active = rst_busy;
    assign cmd_rdata    = {periodic_en, size_s, rst_busy, run_s};

    // R7: while the reset sequence runs, halted is low and run reads 0
    a_r7_busy_state: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |-> (!halted && !cmd_rdata[B_RUN]));

endmodule

// File: tb/hc_cmd_ctrl_tb.sv
module hc_cmd_ctrl_tb;
    localparam time CLK_P = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [4:0] cmd_wdata = '0;
    logic [4:0] cmd_rdata;
    logic prog_fl_cap = 1'b0;
    logic uframe_tick = 1'b0;
    logic txn_pending = 1'b0;
    logic mem_rd_err = 1'b0;
    logic halted, host_err, halt_timeout, reset_active, periodic_en;
    logic [9:0] frame_list_idx;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    hc_cmd_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .prog_fl_cap(prog_fl_cap), .uframe_tick(uframe_tick),
        .txn_pending(txn_pending), .mem_rd_err(mem_rd_err), .halted(halted),
        .host_err(host_err), .halt_timeout(halt_timeout), .reset_active(reset_active),
        .periodic_en(periodic_en), .frame_list_idx(frame_list_idx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = d;
        @(negedge clk); cmd_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); uframe_tick = 1'b1;
        @(negedge clk); uframe_tick = 1'b0;
    endtask

    task automatic do_reset();
        wr(5'b00010);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 halted", halted, 1);
        chk("R1 rdata", cmd_rdata, 0);
        chk("R1 flags", {host_err, halt_timeout, reset_active, periodic_en}, 0);
        chk("R1 idx", frame_list_idx, 0);
    endtask

    task automatic t_run_stop_drain();
        txn_pending = 1'b1;
        wr(5'b00001);
        chk("R2 run set", cmd_rdata[0], 1);
        chk("R2 halted clear", halted, 0);
        wr(5'b00000);
        chk("R3 run clear", cmd_rdata[0], 0);
        tick(); tick(); tick();
        chk("R3 still draining", halted, 0);
        wr(5'b00001);
        chk("R5 run ignored in drain", cmd_rdata[0], 0);
        chk("R5 halted stays low", halted, 0);
        txn_pending = 1'b0;
        @(negedge clk);
        chk("R3 halted after drain", halted, 1);
        chk("R4 no timeout", halt_timeout, 0);
    endtask

    task automatic t_timeout();
        txn_pending = 1'b1;
        wr(5'b00001);
        wr(5'b00000);
        for (int i = 0; i < 15; i++) tick();
        chk("R4 halted before deadline", halted, 0);
        tick();
        chk("R4 halted at deadline", halted, 1);
        chk("R4 timeout flag", halt_timeout, 1);
        txn_pending = 1'b0;
        wr(5'b00001);
        chk("R4 timeout cleared on run", halt_timeout, 0);
        wr(5'b00000);
        @(negedge clk);
    endtask

    task automatic t_mem_err();
        txn_pending = 1'b1;
        wr(5'b00001);
        @(negedge clk); mem_rd_err = 1'b1;
        @(negedge clk); mem_rd_err = 1'b0;
        chk("R6 run cleared", cmd_rdata[0], 0);
        chk("R6 host_err set", host_err, 1);
        chk("R6 draining", halted, 0);
        txn_pending = 1'b0;
        @(negedge clk);
        chk("R6 halted", halted, 1);
        chk("R6 host_err sticky", host_err, 1);
    endtask

    task automatic t_reset_seq();
        prog_fl_cap = 1'b1;
        wr(5'b10101);
        txn_pending = 1'b1;
        @(negedge clk); cmd_we = 1'b1; cmd_wdata = 5'b00010;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cmd_wdata = 5'b11101;
            chk("R7 reset bit reads 1", cmd_rdata[1], 1);
            chk("R7 reset_active", reset_active, 1);
            chk("R7 halted low in reset", halted, 0);
        end
        cmd_we = 1'b0;
        @(negedge clk);
        chk("R7 reset bit cleared", cmd_rdata[1], 0);
        chk("R7 halted after reset", halted, 1);
        chk("R8 writes ignored in reset", cmd_rdata, 0);
        chk("R7 flags cleared", {host_err, halt_timeout, reset_active, periodic_en}, 0);
        txn_pending = 1'b0;
    endtask

    task automatic t_size_per();
        prog_fl_cap = 1'b0;
        wr(5'b01000);
        chk("R9 size locked without cap", cmd_rdata[3:2], 2'b00);
        prog_fl_cap = 1'b1;
        wr(5'b00100);
        chk("R9 size 512", cmd_rdata[3:2], 2'b01);
        wr(5'b01100);
        chk("R9 reserved code ignored", cmd_rdata[3:2], 2'b01);
        wr(5'b10000);
        chk("R10 periodic bit", cmd_rdata[4], 1);
        chk("R10 periodic_en", periodic_en, 1);
        wr(5'b00000);
        chk("R10 periodic off", periodic_en, 0);
    endtask

    task automatic t_frame_idx();
        do_reset();
        prog_fl_cap = 1'b1;
        wr(5'b01001);
        for (int i = 0; i < 2088; i++) tick();
        chk("R11 idx size 256", frame_list_idx, 10'd5);
        wr(5'b00001);
        chk("R11 idx size 1024", frame_list_idx, 10'd261);
        wr(5'b00101);
        chk("R11 idx size 512", frame_list_idx, 10'd261);
        wr(5'b00000);
        @(negedge clk);
        tick(); tick();
        chk("R11 counter holds when halted", frame_list_idx, 10'd261);
        do_reset();
        chk("R7 counter cleared", frame_list_idx, 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset_state();
                t_run_stop_drain();
                t_timeout();
                t_mem_err();
                t_reset_seq();
                t_size_per();
                t_frame_idx();
            end
            begin
                repeat (100000) @(negedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule